// File: doc/BRIEF.md
# Round-Robin Interrupt Selector

This block gathers up to 64 level-sensitive peripheral interrupt lines and keeps a separate enable mask for each of two processors. A source counts as pending for a processor when its status line is high and that processor's mask bit is set. Each processor has a request output that is high while anything is pending for it.

When a processor asks for work, the block picks one pending source for that processor with no fixed priority. The search is circular. It starts at that processor's own resume pointer, and the pointer then moves to just past the source it returned. Every pending source is therefore served in turn. The answer is registered: it appears one cycle after the request, with a flag that says whether a source was found.

Software reads status and mask words and writes mask words through a simple register port. In the 64-source configuration the words are stored in reversed order, so the upper sources sit in word 0. Two single-source operations are also provided:
- An unmask operation sets the bit in each processor's mask if that processor is online and in the source's affinity set, and clears it otherwise.
- A mask operation clears the bit in every processor's mask.

Top module: `irq_rr_select`

## Requirements
- R1: For each processor c, `irq_pend[c]` is high exactly when some source has both `src_status` and processor c's mask bit set, with no cycle of delay from either.
- R2: After reset every mask bit is 0, both resume pointers are 0, and `sel_done`, `sel_valid` and `sel_idx` are 0.
- R3: A `sel_req` in cycle t gives `sel_done`=1 in cycle t+1 (and 0 when there was no request). If anything was pending for `sel_cpu` in cycle t, `sel_valid`=1 and `sel_idx` is the first pending index at or after that processor's pointer, searching upward with wrap.
- R4: After a successful selection, that processor's pointer becomes the returned index plus one. The other processor's pointer does not change.
- R5: A request with nothing pending for that processor gives `sel_valid`=0 and `sel_idx`=0, and leaves the pointer where it was.
- R6: Register word w holds sources 32*(w XOR (words-1)) up to that value plus 31, with bit b of the word being the source base+b. `reg_space`=0 selects status and `reg_space`=1 selects the mask of `reg_cpu`. `reg_rdata` is combinational.
- R7: A write with `reg_space`=1 replaces the addressed mask word of `reg_cpu` from the next cycle on. A write with `reg_space`=0 changes nothing.
- R8: An unmask operation on `op_src` sets the bit for processor c when `cpu_online[c]` and `src_affinity[c]` are both 1, and clears it otherwise. A mask operation clears the bit in every processor and wins over a same-cycle unmask. Either operation wins over a same-cycle register write for its own bit.
- R9: A pick at the last index (NUM_SRC-1) wraps that processor's pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_status | input | NUM_SRC | Peripheral interrupt levels |
| reg_wr | input | 1 | Register write strobe |
| reg_cpu | input | CPU_W | Processor whose mask is addressed |
| reg_space | input | 1 | 0 = status word, 1 = mask word |
| reg_word | input | WAW | Word index (reversed order) |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for the addressed word |
| unmask_req | input | 1 | Affinity-aware unmask of op_src |
| mask_req | input | 1 | Mask op_src in every processor |
| op_src | input | IDX_W | Source index for mask/unmask |
| cpu_online | input | NUM_CPU | Processors currently online |
| src_affinity | input | NUM_CPU | Affinity set of op_src |
| irq_pend | output | NUM_CPU | Something pending per processor |
| sel_req | input | 1 | Ask for the next source |
| sel_cpu | input | CPU_W | Processor that is asking |
| sel_done | output | 1 | Answer present (one cycle after request) |
| sel_valid | output | 1 | A source was found |
| sel_idx | output | IDX_W | Index of the selected source |

## Verification
A wrong resume pointer is invisible until that processor's next selection. There it shows as a wrong `sel_idx`, on the cycle after the request, whenever more than one source is pending. A mask bit that is set or cleared wrongly shows at once on `irq_pend` and on `reg_rdata` when that word is read. A wrong word mapping swaps the halves of a read word. The reference model recomputes all of these every cycle, so such an error is reported within one cycle of reaching a port.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

    typedef enum logic {
        SPACE_STATUS = 1'b0,
        SPACE_MASK   = 1'b1
    } reg_space_e;

    // Register word w maps to physical source group w ^ (words-1).
    function automatic int unsigned flip_word(int unsigned w, int unsigned nw);
        return w ^ (nw - 1);
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_rr_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int WORD_W  = 32,
    parameter int WAW     = 1,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WAW-1:0]     wr_word,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               op_set,
    input  logic               op_clr,
    input  logic [IDX_W-1:0]   op_idx,
    output logic [NUM_SRC-1:0] mask
);
    localparam int NUM_WORDS = NUM_SRC / WORD_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_word == WAW'(w))
                    st_d.bits[flip_word(w, NUM_WORDS)*WORD_W +: WORD_W] = wr_data;
            end
        end
        if (op_clr)
            st_d.bits[op_idx] = 1'b0;
        else if (op_set)
            st_d.bits[op_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.bits;

    // R8: a clear operation leaves the bit at 0
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        op_clr |=> !mask[$past(op_idx)]);

    // R8: a set operation leaves the bit at 1
    a_r8_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (op_set && !op_clr) |=> mask[$past(op_idx)]);

    // R7: with no write and no operation the mask holds
    a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_set && !op_clr) |=> $stable(mask));

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Circular search from start; the descending loop lets the smallest
    // distance from start win. NUM_SRC is a power of two, so the IDX_W
    // addition wraps by itself.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pend[start + IDX_W'(k)]) begin
                found = 1'b1;
                idx   = start + IDX_W'(k);
            end
        end
    end

    // R3: a reported hit is really pending
    a_r3_hit_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pend[idx]);

    // R5: a miss means nothing is pending
    a_r5_miss_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (pend == '0));

endmodule

// File: rtl/irq_rr_select.sv
module irq_rr_select
    import irq_rr_pkg::*;
#(
    parameter  int NUM_SRC   = 64,
    parameter  int NUM_CPU   = 2,
    parameter  int WORD_W    = 32,
    localparam int NUM_WORDS = NUM_SRC / WORD_W,
    localparam int WAW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int IDX_W     = $clog2(NUM_SRC),
    localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_status,
    input  logic               reg_wr,
    input  logic [CPU_W-1:0]   reg_cpu,
    input  logic               reg_space,
    input  logic [WAW-1:0]     reg_word,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               unmask_req,
    input  logic               mask_req,
    input  logic [IDX_W-1:0]   op_src,
    input  logic [NUM_CPU-1:0] cpu_online,
    input  logic [NUM_CPU-1:0] src_affinity,
    output logic [NUM_CPU-1:0] irq_pend,
    input  logic               sel_req,
    input  logic [CPU_W-1:0]   sel_cpu,
    output logic               sel_done,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_idx
);
    typedef struct packed {
        logic [NUM_CPU-1:0][IDX_W-1:0] ptr;
        logic                          done;
        logic                          valid;
        logic [IDX_W-1:0]              idx;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_w;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0]              sel_pend;
    logic [IDX_W-1:0]                sel_start;
    logic                            pick_found;
    logic [IDX_W-1:0]                pick_idx;

    // One mask bank per processor
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic grant;
        assign grant = cpu_online[c] & src_affinity[c];

        irq_mask_bank #(
            .NUM_SRC (NUM_SRC),
            .WORD_W  (WORD_W),
            .WAW     (WAW),
            .IDX_W   (IDX_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && (reg_space == SPACE_MASK) && (reg_cpu == CPU_W'(c))),
            .wr_word (reg_word),
            .wr_data (reg_wdata),
            .op_set  (unmask_req && !mask_req && grant),
            .op_clr  (mask_req || (unmask_req && !grant)),
            .op_idx  (op_src),
            .mask    (mask_w[c])
        );

        assign pend_w[c]   = src_status & mask_w[c];
        assign irq_pend[c] = |pend_w[c];

        // R4: a processor's pointer moves only on its own request
        a_r4_other_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_req || sel_cpu != CPU_W'(c)) |=> $stable(st_q.ptr[c]));
    end

    irq_rr_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (sel_pend),
        .start (sel_start),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Route the requesting processor's pending vector and pointer
    always_comb begin
        sel_pend  = '0;
        sel_start = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (sel_cpu == CPU_W'(c)) begin
                sel_pend  = pend_w[c];
                sel_start = st_q.ptr[c];
            end
        end
    end

    // Register read mux: reversed word order
    always_comb begin
        logic [NUM_SRC-1:0] space_bits;
        space_bits = src_status;
        if (reg_space == SPACE_MASK) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (reg_cpu == CPU_W'(c)) space_bits = mask_w[c];
        end
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_word == WAW'(w))
                reg_rdata = space_bits[flip_word(w, NUM_WORDS)*WORD_W +: WORD_W];
        end
    end

    // Next-state
    always_comb begin
        st_d       = st_q;
        st_d.done  = sel_req;
        st_d.valid = sel_req && pick_found;
        st_d.idx   = (sel_req && pick_found) ? pick_idx : '0;
        if (sel_req && pick_found) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (sel_cpu == CPU_W'(c)) st_d.ptr[c] = pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_done  = st_q.done;
    assign sel_valid = st_q.valid;
    assign sel_idx   = st_q.idx;

    // R3: every request is answered on the next cycle
    a_r3_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        sel_req |=> sel_done);

    // R3: a valid answer never appears without a completed request
    a_r3_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> sel_done);

    // R5: an empty request leaves index 0 and the pointers untouched
    a_r5_empty_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && sel_pend == '0) |=> (!sel_valid && sel_idx == '0 && $stable(st_q.ptr)));

    // R4 / R9: after a hit the pointer sits just past the returned index
    a_r4_ptr_past_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (st_q.ptr[$past(sel_cpu)] == IDX_W'(sel_idx + 1'b1)));

endmodule

// File: tb/irq_rr_select_tb.sv
module irq_rr_select_tb;
    localparam int N  = 64;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_status = '0;
    logic          reg_wr = 1'b0;
    logic          reg_cpu = 1'b0;
    logic          reg_space = 1'b0;
    logic          reg_word = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          unmask_req = 1'b0;
    logic          mask_req = 1'b0;
    logic [5:0]    op_src = '0;
    logic [1:0]    cpu_online = '0;
    logic [1:0]    src_affinity = '0;
    logic [1:0]    irq_pend;
    logic          sel_req = 1'b0;
    logic          sel_cpu = 1'b0;
    logic          sel_done;
    logic          sel_valid;
    logic [5:0]    sel_idx;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    irq_rr_select u_dut (
        .clk(clk), .rst_n(rst_n), .src_status(src_status),
        .reg_wr(reg_wr), .reg_cpu(reg_cpu), .reg_space(reg_space),
        .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .unmask_req(unmask_req), .mask_req(mask_req), .op_src(op_src),
        .cpu_online(cpu_online), .src_affinity(src_affinity),
        .irq_pend(irq_pend), .sel_req(sel_req), .sel_cpu(sel_cpu),
        .sel_done(sel_done), .sel_valid(sel_valid), .sel_idx(sel_idx)
    );

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // Behavioural reference model
    bit [N-1:0] m_mask [2];
    int         m_ptr  [2];
    bit         m_done, m_valid;
    int         m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask[0] = '0; m_mask[1] = '0;
            m_ptr[0] = 0;   m_ptr[1] = 0;
            m_done = 0; m_valid = 0; m_idx = 0;
        end else begin
            bit [N-1:0] p;
            p = src_status & m_mask[sel_cpu];
            m_done = sel_req; m_valid = 0; m_idx = 0;
            if (sel_req) begin
                for (int k = 0; k < N; k++) begin
                    int i;
                    i = (m_ptr[sel_cpu] + k) % N;
                    if (!m_valid && p[i]) begin
                        m_valid = 1; m_idx = i;
                    end
                end
                if (m_valid) m_ptr[sel_cpu] = (m_idx + 1) % N;
            end
            if (reg_wr && reg_space) begin
                int base;
                base = 32 * (int'(reg_word) ^ (NW - 1));
                for (int b = 0; b < 32; b++) m_mask[reg_cpu][base + b] = reg_wdata[b];
            end
            for (int c = 0; c < 2; c++) begin
                if (mask_req) m_mask[c][op_src] = 0;
                else if (unmask_req) m_mask[c][op_src] = cpu_online[c] & src_affinity[c];
            end
        end
    end

    // Every-cycle comparison, away from the clock edges
    always begin
        @(negedge clk);
        #5;
        if (cmp_en) begin
            bit [N-1:0] sp;
            bit [31:0]  er;
            int base;
            sp = reg_space ? m_mask[reg_cpu] : src_status;
            base = 32 * (int'(reg_word) ^ (NW - 1));
            for (int b = 0; b < 32; b++) er[b] = sp[base + b];
            chk("R1 irq_pend", 64'(irq_pend),
                64'({|(src_status & m_mask[1]), |(src_status & m_mask[0])}));
            chk("R3 sel_done", 64'(sel_done), 64'(m_done));
            chk(m_done && !m_valid ? "R5 sel_valid" : "R3 sel_valid", 64'(sel_valid), 64'(m_valid));
            chk(m_done && !m_valid ? "R5 sel_idx" : "R4 sel_idx", 64'(sel_idx), 64'(m_idx));
            chk("R6 reg_rdata", 64'(reg_rdata), 64'(er));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog R3 got cycles=%0d exp below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic wr_mask(bit cpu, bit word, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_space = 1; reg_cpu = cpu; reg_word = word; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(bit space, bit cpu, bit word, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_space = space; reg_cpu = cpu; reg_word = word;
        #5;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic pick(bit cpu, bit exp_v, logic [5:0] exp_i, string tag);
        @(negedge clk);
        sel_req = 1; sel_cpu = cpu;
        @(negedge clk);
        sel_req = 0;
        #5;
        chk(tag, 64'({sel_done, sel_valid, sel_idx}), 64'({1'b1, exp_v, exp_i}));
    endtask

    task automatic op(bit un, bit ms, logic [5:0] s, logic [1:0] onl, logic [1:0] aff);
        @(negedge clk);
        unmask_req = un; mask_req = ms; op_src = s; cpu_online = onl; src_affinity = aff;
        @(negedge clk);
        unmask_req = 0; mask_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        #5;
        chk("R2 reset sel outputs", 64'({sel_done, sel_valid, sel_idx}), 64'(0));
        chk("R2 reset irq_pend", 64'(irq_pend), 64'(0));
        rd(1, 0, 0, 32'h0, "R2 reset mask word");

        // Word order and mask writes
        src_status = (64'h1 << 0) | (64'h1 << 4) | (64'h1 << 40);
        wr_mask(0, 1, 32'h0000_0011);
        rd(1, 0, 1, 32'h0000_0011, "R7 mask write");
        rd(0, 0, 0, 32'h0000_0100, "R6 status word0 holds upper sources");
        rd(0, 0, 1, 32'h0000_0011, "R6 status word1 holds lower sources");
        @(negedge clk);
        reg_wr = 1; reg_space = 0; reg_cpu = 0; reg_word = 1; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wr = 0;
        rd(1, 0, 1, 32'h0000_0011, "R7 status write ignored cpu0");
        rd(1, 1, 1, 32'h0, "R7 status write ignored cpu1");
        chk("R1 pending cpu0 only", 64'(irq_pend), 64'(2'b01));

        // Rotation for cpu0
        pick(0, 1, 6'd0, "R3 first pick from pointer 0");
        pick(0, 1, 6'd4, "R4 resume after 0");
        pick(0, 1, 6'd0, "R4 rotate back to 0");
        pick(1, 0, 6'd0, "R5 nothing pending cpu1");

        // Affinity-aware unmask
        src_status = src_status | (64'h1 << 1) | (64'h1 << 63);
        op(1, 0, 6'd63, 2'b11, 2'b10);
        rd(1, 1, 0, 32'h8000_0000, "R8 unmask grants cpu1");
        rd(1, 0, 0, 32'h0, "R8 unmask denies cpu0");
        op(1, 0, 6'd1, 2'b10, 2'b11);
        rd(1, 1, 1, 32'h0000_0002, "R8 unmask src1 cpu1");
        rd(1, 0, 1, 32'h0000_0011, "R8 offline cpu0 bit cleared");

        // Wrap for cpu1; cpu0 pointer untouched
        pick(1, 1, 6'd1,  "R9 cpu1 first from 0");
        pick(1, 1, 6'd63, "R9 cpu1 last index");
        pick(1, 1, 6'd1,  "R9 pointer wrapped to 0");
        pick(0, 1, 6'd4,  "R4 cpu0 pointer independent");

        // Mask operations and precedence
        op(0, 1, 6'd4, 2'b11, 2'b11);
        rd(1, 0, 1, 32'h0000_0001, "R8 mask clears cpu0");
        op(1, 1, 6'd0, 2'b11, 2'b11);
        rd(1, 0, 1, 32'h0, "R8 mask wins over unmask");
        @(negedge clk);
        reg_wr = 1; reg_space = 1; reg_cpu = 0; reg_word = 1; reg_wdata = 32'hFFFF_FFFF;
        mask_req = 1; op_src = 6'd2;
        @(negedge clk);
        reg_wr = 0; mask_req = 0;
        rd(1, 0, 1, 32'hFFFF_FFFB, "R8 operation wins over write");

        // Random traffic checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            src_status = (n % 3 == 0) ? {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                                      : {$urandom, $urandom};
            reg_wr       = ($urandom % 8) == 0;
            reg_space    = $urandom;
            reg_cpu      = $urandom;
            reg_word     = $urandom;
            reg_wdata    = $urandom & $urandom;
            unmask_req   = ($urandom % 6) == 0;
            mask_req     = ($urandom % 10) == 0;
            op_src       = 6'($urandom);
            cpu_online   = 2'($urandom);
            src_affinity = 2'($urandom);
            sel_req      = $urandom;
            sel_cpu      = $urandom;
        end
        @(negedge clk);
        reg_wr = 0; unmask_req = 0; mask_req = 0; sel_req = 0;
        repeat (3) @(negedge clk);
        #6;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule